// File: doc/BRIEF.md
# Lockable Set-Associative Instruction Cache

This block is an instruction cache with four ways per set. A fetch that hits returns one 64-bit word, which holds two 32-bit instructions, in the cycle after the request is accepted. A fetch that misses issues one line request to the next memory level. The line then arrives as four 64-bit beats, one beat per cycle, and is written into a way chosen by the replacement logic. The requested word is returned once the line is complete.

Software can pin any line in place by setting a lock bit in its tag entry through a small maintenance port. A locked way is never chosen for replacement, so the code it holds stays resident and its fetch timing is predictable. When every way of a set is locked, a miss still returns the right data but allocates no line.

Every 32-bit data word and every tag entry carries a parity bit. A parity mismatch on a hit is handled as a miss: the line is invalidated and fetched again into the same way, and an error flag pulses for one cycle. The maintenance port can also flip a stored data parity bit, so the error path can be exercised on purpose.

Top module: `lockable_icache`

## Requirements
- R1: With default parameters the cache holds 16 KB as 128 sets of four 32-byte lines. Fetch address bits [31:12] form the tag, bits [11:5] select the set, bits [4:3] select the 64-bit word within the line, and bits [2:0] are ignored.
- R2: A fetch accepted with `fetchValid` high and `fetchReady` high, whose tag matches a valid way with good parity, raises `rspValid` in the next cycle. `rspData` then carries the addressed 64-bit word, and no memory request is issued.
- R3: On a miss, `memReqValid` is high for exactly one cycle, the cycle after acceptance, carrying the line-aligned byte address. The cache then takes four beats on `memBeatValid`; beat k holds line bytes 8k to 8k+7. `rspValid` is raised in the second cycle after the cycle that carries the last beat, with the requested word.
- R4: `fetchReady` is low from the acceptance of a miss until its response has been delivered. It is also low in any cycle in which `maintValid` is high; maintenance takes priority over fetch.
- R5: A miss allocates the lowest-numbered way that is both invalid and unlocked. If there is none, the first unlocked way at or after the set's round-robin pointer is used. After each allocating fill, the pointer becomes the victim way plus one (modulo four). Pointers reset to zero.
- R6: A way whose lock bit is set is never overwritten by a miss. Locked lines keep hitting while other lines of the set are replaced.
- R7: When all four ways of the addressed set are locked, a miss returns the correct word as a pass-through read and replaces nothing. A repeated fetch of the same line misses again.
- R8: Maintenance ops act on the way given by `maintWay` in the set given by `maintAddr[11:5]`. Op 2'b01 sets the lock bit, op 2'b00 clears it, and the change governs every later miss.
- R9: Even parity is generated for each 32-bit half of every beat as it is filled, and for each tag entry. Op 2'b10 flips the stored parity bit of the lower half of the word selected by `maintAddr[4:3]`, which affects only that word.
- R10: A parity mismatch on a hit pulses `parityErr` for one cycle, the cycle after acceptance, with no `rspValid` in that cycle. The line is refetched into the same way with its lock bit kept, the correct word is returned, and later fetches of the line hit without error.
- R11: After reset `fetchReady` is high, `rspValid`, `memReqValid` and `parityErr` are low, and every line is invalid and unlocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| fetchValid | input | 1 | Fetch request valid |
| fetchAddr | input | ADDR_W | Fetch byte address |
| fetchReady | output | 1 | Cache can accept a fetch this cycle |
| rspValid | output | 1 | Response word valid |
| rspData | output | BEAT_W | Two instructions; the lower address is in bits 31:0 |
| parityErr | output | 1 | One-cycle pulse on a parity mismatch at a hit |
| memReqValid | output | 1 | Line request to the next level |
| memReqAddr | output | ADDR_W | Line-aligned request address |
| memBeatValid | input | 1 | Fill beat valid |
| memBeatData | input | BEAT_W | Fill beat data |
| maintValid | input | 1 | Maintenance op valid |
| maintAddr | input | ADDR_W | Address whose set (and word, for the parity flip) is targeted |
| maintWay | input | WAY_W | Target way |
| maintOp | input | 2 | 00 unlock, 01 lock, 10 flip parity, 11 no operation |

## Verification
The hardest state to reach from the ports is a set whose ways hold a known mix of locked and unlocked lines, with the round-robin pointer at a known position. Only that state makes the victim choice observable as hits and misses. The stimulus fills one set from empty, so the invalid-way rule places line k in way k, then locks chosen ways by number. Further misses then push the pointer through a sequence that can be predicted. A parity error on a hit cannot arise from normal fills, so the stimulus flips a stored parity bit through the maintenance port. The bench then confirms that only the corrupted word reports an error, and that the repaired line stays locked.

// File: rtl/icache_pkg.sv
package icache_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_FILL = 2'd2,
    ST_RESP = 2'd3
  } fillStateT;

  typedef enum logic [1:0] {
    MOP_UNLOCK = 2'b00,
    MOP_LOCK   = 2'b01,
    MOP_FLIP   = 2'b10,
    MOP_NONE   = 2'b11
  } maintOpT;

  // Strobes from the controller to the datapath
  typedef struct packed {
    logic hitResp;     // accepted fetch hit with good parity
    logic latchMiss;   // accepted fetch needs a refill
    logic invalidate;  // parity failure on hit: drop the line
    logic beatWrite;   // a fill beat is present
    logic lastBeat;    // final beat of the line
    logic bufResp;     // deliver the buffered refill word
    logic maintApply;  // perform the maintenance op
  } ctrlStrobeT;

endpackage

// File: rtl/icache_victim_sel.sv
module icache_victim_sel #(
  parameter int WAYS  = 4,
  parameter int WAY_W = 2
) (
  input  logic [WAYS-1:0]  validVec,
  input  logic [WAYS-1:0]  lockVec,
  input  logic [WAY_W-1:0] rrPtr,
  output logic [WAY_W-1:0] victim,
  output logic             allLocked
);

  always_comb begin
    logic found;
    victim = '0;
    found  = 1'b0;
    // First choice: an invalid way that is not locked
    for (int w = 0; w < WAYS; w++) begin
      if (!found && !lockVec[w] && !validVec[w]) begin
        victim = WAY_W'(w);
        found  = 1'b1;
      end
    end
    // Otherwise: round-robin over unlocked ways starting at the pointer
    for (int k = 0; k < WAYS; k++) begin
      int cand;
      cand = (int'(rrPtr) + k) % WAYS;
      if (!found && !lockVec[cand]) begin
        victim = WAY_W'(cand);
        found  = 1'b1;
      end
    end
    allLocked = &lockVec;
  end

endmodule

// File: rtl/icache_ctrl.sv
module icache_ctrl
  import icache_pkg::*;
#(
  parameter int BEATS      = 4,
  parameter int BEAT_IDX_W = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  fetchValid,
  input  logic                  maintValid,
  input  logic                  memBeatValid,
  input  logic                  lookupHit,
  input  logic                  lookupPerr,
  output ctrlStrobeT            stb,
  output logic [BEAT_IDX_W-1:0] beatIdx,
  output logic                  fetchReady,
  output logic                  memReqValid
);

  fillStateT state, stateNext;
  logic [BEAT_IDX_W-1:0] beatCnt;
  logic accept;

  assign fetchReady  = (state == ST_IDLE) && !maintValid;
  assign memReqValid = (state == ST_REQ);
  assign beatIdx     = beatCnt;

  always_comb begin
    accept         = (state == ST_IDLE) && fetchValid && !maintValid;
    stb            = '0;
    stb.maintApply = (state == ST_IDLE) && maintValid;
    stb.hitResp    = accept && lookupHit && !lookupPerr;
    stb.latchMiss  = accept && !(lookupHit && !lookupPerr);
    stb.invalidate = accept && lookupPerr;
    stb.beatWrite  = (state == ST_FILL) && memBeatValid;
    stb.lastBeat   = stb.beatWrite && (beatCnt == BEAT_IDX_W'(BEATS - 1));
    stb.bufResp    = (state == ST_RESP);
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: if (stb.latchMiss) stateNext = ST_REQ;
      ST_REQ:  stateNext = ST_FILL;
      ST_FILL: if (stb.lastBeat) stateNext = ST_RESP;
      ST_RESP: stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      beatCnt <= '0;
    end else begin
      state <= stateNext;
      if (state == ST_REQ)    beatCnt <= '0;
      else if (stb.beatWrite) beatCnt <= beatCnt + 1'b1;
    end
  end

endmodule

// File: rtl/icache_datapath.sv
module icache_datapath
  import icache_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int BEAT_W     = 64,
  parameter int WAYS       = 4,
  parameter int SETS       = 128,
  parameter int BEATS      = 4,
  parameter int WAY_W      = 2,
  parameter int IDX_W      = 7,
  parameter int TAG_W      = 20,
  parameter int LINE_OFF   = 5,
  parameter int WORD_OFF   = 3,
  parameter int BEAT_IDX_W = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [ADDR_W-1:0]     fetchAddr,
  input  logic [ADDR_W-1:0]     maintAddr,
  input  logic [WAY_W-1:0]      maintWay,
  input  logic [1:0]            maintOp,
  input  ctrlStrobeT            stb,
  input  logic [BEAT_IDX_W-1:0] beatIdx,
  input  logic [BEAT_W-1:0]     memBeatData,
  output logic                  lookupHit,
  output logic                  lookupPerr,
  output logic                  rspValid,
  output logic [BEAT_W-1:0]     rspData,
  output logic                  parityErr,
  output logic [ADDR_W-1:0]     memReqAddr
);

  localparam int ENTRIES = SETS * WAYS;
  localparam int WORDS   = ENTRIES * BEATS;
  localparam int HALVES  = BEAT_W / 32;
  localparam int ENT_W   = IDX_W + WAY_W;

  function automatic logic [HALVES-1:0] parOf(input logic [BEAT_W-1:0] d);
    logic [HALVES-1:0] p;
    for (int h = 0; h < HALVES; h++) p[h] = ^d[h*32 +: 32];
    return p;
  endfunction

  // Storage
  logic [TAG_W-1:0]  tagMem  [ENTRIES];
  logic [BEAT_W-1:0] dataMem [WORDS];
  logic [HALVES-1:0] dataPar [WORDS];
  logic [ENTRIES-1:0] validBits, lockBits, tagParBits;
  logic [WAY_W-1:0]  rrPtr   [SETS];

  // Fetch address fields
  logic [IDX_W-1:0]      fIdx;
  logic [TAG_W-1:0]      fTag;
  logic [BEAT_IDX_W-1:0] fWord;
  assign fIdx  = fetchAddr[LINE_OFF +: IDX_W];
  assign fTag  = fetchAddr[ADDR_W-1 -: TAG_W];
  assign fWord = fetchAddr[WORD_OFF +: BEAT_IDX_W];

  // Maintenance address fields
  logic [IDX_W-1:0]      mIdx;
  logic [BEAT_IDX_W-1:0] mWord;
  logic [ENT_W-1:0]      mEnt;
  assign mIdx  = maintAddr[LINE_OFF +: IDX_W];
  assign mWord = maintAddr[WORD_OFF +: BEAT_IDX_W];
  assign mEnt  = {mIdx, maintWay};

  // Per-way lookup
  logic [WAYS-1:0]   wayValid, wayLock, wayHit, wayParOk;
  logic [BEAT_W-1:0] wayWord [WAYS];

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [ENT_W-1:0] ent;
    assign ent         = {fIdx, WAY_W'(w)};
    assign wayValid[w] = validBits[ent];
    assign wayLock[w]  = lockBits[ent];
    assign wayHit[w]   = validBits[ent] && (tagMem[ent] == fTag);
    assign wayWord[w]  = dataMem[{ent, fWord}];
    assign wayParOk[w] = (dataPar[{ent, fWord}] == parOf(wayWord[w])) &&
                         (tagParBits[ent] == ^{tagMem[ent], 1'b1, lockBits[ent]});
  end

  logic [WAY_W-1:0]  hitWay;
  logic [BEAT_W-1:0] hitData;

  always_comb begin
    hitWay = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (wayHit[w]) hitWay = WAY_W'(w);
    end
  end

  assign lookupHit  = |wayHit;
  assign hitData    = wayWord[hitWay];
  assign lookupPerr = lookupHit && !wayParOk[hitWay];

  // Replacement choice
  logic [WAY_W-1:0] victim;
  logic             allLocked;

  icache_victim_sel #(.WAYS(WAYS), .WAY_W(WAY_W)) u_victim (
    .validVec (wayValid),
    .lockVec  (wayLock),
    .rrPtr    (rrPtr[fIdx]),
    .victim   (victim),
    .allLocked(allLocked)
  );

  // Refill context
  logic [TAG_W-1:0]      reqTag;
  logic [IDX_W-1:0]      reqIdx;
  logic [BEAT_IDX_W-1:0] reqWord;
  logic [WAY_W-1:0]      fillWay;
  logic                  bypass, repair;
  logic [BEAT_W-1:0]     fillBuf;
  logic [ENT_W-1:0]      fillEnt;

  assign fillEnt    = {reqIdx, fillWay};
  assign memReqAddr = {reqTag, reqIdx, LINE_OFF'(0)};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqTag  <= '0;
      reqIdx  <= '0;
      reqWord <= '0;
      fillWay <= '0;
      bypass  <= 1'b0;
      repair  <= 1'b0;
      fillBuf <= '0;
    end else begin
      if (stb.latchMiss) begin
        reqTag  <= fTag;
        reqIdx  <= fIdx;
        reqWord <= fWord;
        fillWay <= lookupPerr ? hitWay : victim;
        bypass  <= !lookupPerr && allLocked;
        repair  <= lookupPerr;
      end
      if (stb.beatWrite && (beatIdx == reqWord)) fillBuf <= memBeatData;
    end
  end

  // Data array and tag fields that need no reset
  always_ff @(posedge clk) begin
    if (stb.beatWrite && !bypass) begin
      dataMem[{fillEnt, beatIdx}] <= memBeatData;
      dataPar[{fillEnt, beatIdx}] <= parOf(memBeatData);
    end
    if (stb.maintApply && (maintOp == MOP_FLIP)) begin
      dataPar[{mEnt, mWord}][0] <= ~dataPar[{mEnt, mWord}][0];
    end
    if (stb.lastBeat && !bypass) tagMem[fillEnt] <= reqTag;
  end

  // Line state with reset
  always_ff @(posedge clk) begin
    if (!rstN) begin
      validBits  <= '0;
      lockBits   <= '0;
      tagParBits <= '0;
      for (int s = 0; s < SETS; s++) rrPtr[s] <= '0;
    end else begin
      if (stb.invalidate) validBits[{fIdx, hitWay}] <= 1'b0;
      if (stb.lastBeat && !bypass) begin
        validBits[fillEnt]  <= 1'b1;
        tagParBits[fillEnt] <= ^{reqTag, 1'b1, lockBits[fillEnt]};
        if (!repair) rrPtr[reqIdx] <= fillWay + 1'b1;
      end
      if (stb.maintApply && (maintOp == MOP_LOCK || maintOp == MOP_UNLOCK)) begin
        lockBits[mEnt]   <= (maintOp == MOP_LOCK);
        tagParBits[mEnt] <= ^{tagMem[mEnt], validBits[mEnt], maintOp == MOP_LOCK};
      end
    end
  end

  // Registered response
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid  <= 1'b0;
      rspData   <= '0;
      parityErr <= 1'b0;
    end else begin
      rspValid  <= stb.hitResp || stb.bufResp;
      parityErr <= stb.invalidate;
      if (stb.hitResp)      rspData <= hitData;
      else if (stb.bufResp) rspData <= fillBuf;
    end
  end

endmodule

// File: rtl/lockable_icache.sv
module lockable_icache
  import icache_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int BEAT_W      = 64,
  parameter int WAYS        = 4,
  parameter int LINE_BYTES  = 32,
  parameter int CACHE_BYTES = 16384,
  localparam int WAY_W      = $clog2(WAYS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              fetchValid,
  input  logic [ADDR_W-1:0] fetchAddr,
  output logic              fetchReady,
  output logic              rspValid,
  output logic [BEAT_W-1:0] rspData,
  output logic              parityErr,
  output logic              memReqValid,
  output logic [ADDR_W-1:0] memReqAddr,
  input  logic              memBeatValid,
  input  logic [BEAT_W-1:0] memBeatData,
  input  logic              maintValid,
  input  logic [ADDR_W-1:0] maintAddr,
  input  logic [WAY_W-1:0]  maintWay,
  input  logic [1:0]        maintOp
);

  localparam int SETS       = CACHE_BYTES / (WAYS * LINE_BYTES);
  localparam int BEATS      = LINE_BYTES / (BEAT_W / 8);
  localparam int WORD_OFF   = $clog2(BEAT_W / 8);
  localparam int LINE_OFF   = $clog2(LINE_BYTES);
  localparam int IDX_W      = $clog2(SETS);
  localparam int TAG_W      = ADDR_W - IDX_W - LINE_OFF;
  localparam int BEAT_IDX_W = $clog2(BEATS);

  ctrlStrobeT            stb;
  logic [BEAT_IDX_W-1:0] beatIdx;
  logic                  lookupHit, lookupPerr;

  icache_ctrl #(.BEATS(BEATS), .BEAT_IDX_W(BEAT_IDX_W)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .fetchValid  (fetchValid),
    .maintValid  (maintValid),
    .memBeatValid(memBeatValid),
    .lookupHit   (lookupHit),
    .lookupPerr  (lookupPerr),
    .stb         (stb),
    .beatIdx     (beatIdx),
    .fetchReady  (fetchReady),
    .memReqValid (memReqValid)
  );

  icache_datapath #(
    .ADDR_W(ADDR_W), .BEAT_W(BEAT_W), .WAYS(WAYS), .SETS(SETS), .BEATS(BEATS),
    .WAY_W(WAY_W), .IDX_W(IDX_W), .TAG_W(TAG_W), .LINE_OFF(LINE_OFF),
    .WORD_OFF(WORD_OFF), .BEAT_IDX_W(BEAT_IDX_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .fetchAddr  (fetchAddr),
    .maintAddr  (maintAddr),
    .maintWay   (maintWay),
    .maintOp    (maintOp),
    .stb        (stb),
    .beatIdx    (beatIdx),
    .memBeatData(memBeatData),
    .lookupHit  (lookupHit),
    .lookupPerr (lookupPerr),
    .rspValid   (rspValid),
    .rspData    (rspData),
    .parityErr  (parityErr),
    .memReqAddr (memReqAddr)
  );

endmodule

// File: rtl/icache_sva.sv
module icache_sva (
  input logic clk,
  input logic rstN,
  input logic fetchValid,
  input logic fetchReady,
  input logic maintValid,
  input logic rspValid,
  input logic parityErr,
  input logic memReqValid
);

  // R4
  maint_blocks_fetch_chk: assert property (@(posedge clk) disable iff (!rstN)
    maintValid |-> !fetchReady);

  // R4
  busy_during_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> !fetchReady);

  // R3
  req_one_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |=> !memReqValid);

  // R2
  accept_outcome_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fetchValid && fetchReady) |=> (rspValid != memReqValid));

  // R10
  perr_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    parityErr |=> !parityErr);

  // R10
  perr_refetch_chk: assert property (@(posedge clk) disable iff (!rstN)
    parityErr |-> (!rspValid && memReqValid));

endmodule

bind lockable_icache icache_sva u_sva (
  .clk        (clk),
  .rstN       (rstN),
  .fetchValid (fetchValid),
  .fetchReady (fetchReady),
  .maintValid (maintValid),
  .rspValid   (rspValid),
  .parityErr  (parityErr),
  .memReqValid(memReqValid)
);

// File: tb/tb_lockable_icache.sv
module tb_lockable_icache;

  localparam int CLK_NS = 20;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        fetchValid = 1'b0;
  logic [31:0] fetchAddr = '0;
  logic        fetchReady, rspValid, parityErr, memReqValid;
  logic [63:0] rspData;
  logic [31:0] memReqAddr;
  logic        memBeatValid = 1'b0;
  logic [63:0] memBeatData = '0;
  logic        maintValid = 1'b0;
  logic [31:0] maintAddr = '0;
  logic [1:0]  maintWay = '0;
  logic [1:0]  maintOp = '0;

  always #(CLK_NS / 2) clk = ~clk;

  lockable_icache dut (
    .clk(clk), .rstN(rstN), .fetchValid(fetchValid), .fetchAddr(fetchAddr),
    .fetchReady(fetchReady), .rspValid(rspValid), .rspData(rspData),
    .parityErr(parityErr), .memReqValid(memReqValid), .memReqAddr(memReqAddr),
    .memBeatValid(memBeatValid), .memBeatData(memBeatData),
    .maintValid(maintValid), .maintAddr(maintAddr), .maintWay(maintWay),
    .maintOp(maintOp)
  );

  int testsRun = 0;
  int testsFailed = 0;
  int memReqCount = 0;
  int perrCount = 0;
  logic [63:0] expQ[$];
  string       reqQ[$];

  function automatic logic [63:0] memWord(input logic [31:0] a);
    logic [31:0] b;
    b = {a[31:3], 3'b000};
    return {~b, b ^ 32'h1234_5678};
  endfunction

  function automatic logic [31:0] addrOf(input int tag, input int idx, input int word);
    return (32'(tag) << 12) | (32'(idx) << 5) | (32'(word) << 3);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Next-level memory: three-cycle latency, then four beats
  initial begin
    forever begin
      @(negedge clk);
      if (memReqValid) begin
        logic [31:0] lineA;
        lineA = memReqAddr;
        memReqCount++;
        check(lineA[4:0] == 5'd0, "R3", "line-aligned request", 64'(lineA), 64'(lineA & ~32'h1f));
        repeat (3) @(negedge clk);
        for (int b = 0; b < 4; b++) begin
          memBeatValid = 1'b1;
          memBeatData  = memWord(lineA + 32'(b * 8));
          @(negedge clk);
        end
        memBeatValid = 1'b0;
      end
    end
  end

  // Monitor: compares responses against the scoreboard queue
  always @(negedge clk) begin
    if (rstN) begin
      if (parityErr) perrCount++;
      if (rspValid) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R2", "unexpected response", rspData, 64'd0);
        end else begin
          logic [63:0] e;
          string r;
          e = expQ.pop_front();
          r = reqQ.pop_front();
          check(rspData === e, r, "response data", rspData, e);
        end
      end
    end
  end

  task automatic doFetch(input logic [31:0] addr, input bit expHit, input bit expErr,
                         input string req);
    int reqBefore, errBefore, n;
    reqBefore = memReqCount;
    errBefore = perrCount;
    expQ.push_back(memWord(addr));
    reqQ.push_back(req);
    @(negedge clk);
    fetchValid = 1'b1;
    fetchAddr  = addr;
    while (!fetchReady) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    fetchValid = 1'b0;
    if (expHit) check(rspValid === 1'b1, req, "hit response next cycle", 64'(rspValid), 64'd1);
    else        check(fetchReady === 1'b0, "R4", "not ready during refill", 64'(fetchReady), 64'd0);
    n = 0;
    while (expQ.size() != 0 && n < 100) begin
      @(negedge clk);
      n++;
    end
    check(memReqCount - reqBefore == (expHit ? 0 : 1), req, "memory request count",
          64'(memReqCount - reqBefore), expHit ? 64'd0 : 64'd1);
    check(perrCount - errBefore == int'(expErr), "R10", "parity error pulses",
          64'(perrCount - errBefore), 64'(expErr));
  endtask

  task automatic doMaint(input logic [31:0] addr, input logic [1:0] way, input logic [1:0] op);
    @(negedge clk);
    maintValid = 1'b1;
    maintAddr  = addr;
    maintWay   = way;
    maintOp    = op;
    #1;
    check(fetchReady === 1'b0, "R4", "ready low during maintenance", 64'(fetchReady), 64'd0);
    @(negedge clk);
    maintValid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    testsRun++;
    testsFailed++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R11 reset state
    check(fetchReady === 1'b1, "R11", "fetchReady after reset", 64'(fetchReady), 64'd1);
    check(rspValid === 1'b0, "R11", "rspValid after reset", 64'(rspValid), 64'd0);
    check(memReqValid === 1'b0, "R11", "memReqValid after reset", 64'(memReqValid), 64'd0);
    check(parityErr === 1'b0, "R11", "parityErr after reset", 64'(parityErr), 64'd0);

    // R3 / R2 / R1 basic miss then hits, set 0
    doFetch(addrOf(3, 0, 2), 0, 0, "R3");
    doFetch(addrOf(3, 0, 0), 1, 0, "R2");
    doFetch(addrOf(3, 0, 2) | 32'd4, 1, 0, "R1");
    doFetch(addrOf(3, 0, 3), 1, 0, "R2");
    doFetch(addrOf(9, 127, 3), 0, 0, "R1");
    doFetch(addrOf(9, 127, 1), 1, 0, "R1");

    // R5 fill set 5 from empty: line k lands in way k
    for (int k = 0; k < 4; k++) doFetch(addrOf(k, 5, k), 0, 0, "R5");
    for (int k = 0; k < 4; k++) doFetch(addrOf(k, 5, 1), 1, 0, "R5");

    // R8 lock ways 0 and 1; pointer is 0, so next victim is way 2
    doMaint(addrOf(0, 5, 0), 2'd0, 2'b01);
    doMaint(addrOf(0, 5, 0), 2'd1, 2'b01);
    doFetch(addrOf(4, 5, 0), 0, 0, "R5");
    doFetch(addrOf(0, 5, 2), 1, 0, "R6");
    doFetch(addrOf(1, 5, 3), 1, 0, "R6");
    doFetch(addrOf(3, 5, 0), 1, 0, "R5");
    doFetch(addrOf(4, 5, 1), 1, 0, "R5");
    doFetch(addrOf(2, 5, 0), 0, 0, "R5");   // lands in way 3

    // R7 all ways locked: pass-through, no allocation
    doMaint(addrOf(0, 5, 0), 2'd2, 2'b01);
    doMaint(addrOf(0, 5, 0), 2'd3, 2'b01);
    doFetch(addrOf(5, 5, 2), 0, 0, "R7");
    doFetch(addrOf(5, 5, 2), 0, 0, "R7");
    doFetch(addrOf(4, 5, 3), 1, 0, "R7");
    doFetch(addrOf(2, 5, 1), 1, 0, "R7");

    // R8 unlock way 2 only: it becomes the sole victim
    doMaint(addrOf(0, 5, 0), 2'd2, 2'b00);
    doFetch(addrOf(5, 5, 0), 0, 0, "R8");
    doFetch(addrOf(5, 5, 1), 1, 0, "R8");
    doFetch(addrOf(4, 5, 0), 0, 0, "R6");
    doFetch(addrOf(2, 5, 0), 1, 0, "R6");
    doFetch(addrOf(0, 5, 0), 1, 0, "R6");
    doFetch(addrOf(1, 5, 0), 1, 0, "R6");

    // R9 / R10 parity fault injection on locked line in way 1, word 1
    doMaint(addrOf(1, 5, 1), 2'd1, 2'b10);
    doFetch(addrOf(1, 5, 0), 1, 0, "R9");
    doFetch(addrOf(1, 5, 1), 0, 1, "R10");
    doFetch(addrOf(1, 5, 1), 1, 0, "R10");
    doFetch(addrOf(6, 5, 0), 0, 0, "R10"); // must replace way 2, not repaired way 1
    doFetch(addrOf(1, 5, 2), 1, 0, "R10");
    doMaint(addrOf(0, 5, 0), 2'd0, 2'b10);
    doFetch(addrOf(0, 5, 2), 1, 0, "R9");
    doFetch(addrOf(0, 5, 0), 0, 1, "R10");
    doFetch(addrOf(0, 5, 0), 1, 0, "R10");

    repeat (4) @(negedge clk);
    check(expQ.size() == 0, "R2", "all responses delivered", 64'(expQ.size()), 64'd0);
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule